// File: doc/BRIEF.md
# Dual divided-clock sine tone synthesizer

This block produces the digital sample stream for a dual-tone telephone dialling signal. It runs from a 3.579545 MHz reference clock and contains two tone groups, a low group and a high group. Each group divides the reference clock by an integer ratio chosen by a 2-bit selector. Each terminal count of that divider moves the group one step through a 28-step sine cycle, and every step lasts the same number of clocks.

Each group's phase is turned into a signed 8-bit sample taken from a rounded sine table. The high-group sample is multiplied by 11/8, which gives about 2.8 dB of pre-emphasis. The two samples are then added and registered into a single 10-bit signed word. A keypad decoder upstream drives the two enables and the two selectors. A group that is not enabled adds zero, and with both groups off the output word is zero. Conversion to analogue, supply tracking and filtering belong to later stages.

Top module: `tone_pair_synth`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `tone_out` is 0 after that edge, and both groups restart from step 0 with a count of 0.
- R2: Low-group step length in clocks depends on `low_sel`: 0 gives 184, 1 gives 166, 2 gives 150 and 3 gives 136.
- R3: High-group step length in clocks depends on `high_sel`: 0 gives 106, 1 gives 96, 2 gives 86 and 3 gives 78.
- R4: A sine cycle has 28 steps. At step p the sample is round(127*sin(2*pi*p/28)) as a signed 8-bit value. Step 27 is followed by step 0.
- R5: While a group's enable is low, its step and clock count return to 0. On the k-th rising edge with the enable high (k counted from 0 since it was last low or since reset), the output word uses that group's step floor(k/N) mod 28, where N is the group's step length.
- R6: Before summing, the high-group sample s is replaced by floor(11*s/8).
- R7: `tone_out` is registered. After each rising edge it equals the low contribution plus the high contribution computed from the inputs at that edge. A disabled group contributes 0, so with both enables low the output is 0.
- R8: `tone_out` always stays within -302 to +301.
- R9: Turning one group on or off has no effect on the step sequence of the other group.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock, 3.579545 MHz nominal |
| rst_n | input | 1 | Synchronous active-low reset |
| low_en | input | 1 | Low-group enable |
| low_sel | input | 2 | Low-group frequency selector |
| high_en | input | 1 | High-group enable |
| high_sel | input | 2 | High-group frequency selector |
| tone_out | output | 10 | Signed sum of both group samples |

## Verification
The checker's bounds on the clock count assume that a group's selector does not change while that group is enabled. A lower step length chosen in mid-count would leave the count above the new limit for a short time. The stimulus therefore changes a selector only in a cycle where that group's enable is low, and it turns groups on and off only between clock edges. Enables may go high or low at any edge and reset may arrive in mid-tone. The reference model restarts its step counts in those cases, and the checker's step-progression properties take those restarts into account.

// File: rtl/tone_pkg.sv
// tone_pkg: shared widths, divide ratios and sine quarter-wave values for
// the dual tone synthesizer. Assumes a 28-step cycle so that a quarter
// wave is exactly 7 steps.
package tone_pkg;
    localparam int STEPS      = 28;
    localparam int HALF       = STEPS / 2;
    localparam int QUARTER    = STEPS / 4;
    localparam int SAMPLE_W   = 8;
    localparam int PEAK       = 127;
    localparam int SEL_W      = 2;
    localparam int NUM_SEL    = 1 << SEL_W;
    localparam int DIV_W      = 8;
    localparam int PH_W       = $clog2(STEPS);
    localparam int EMPH_NUM   = 11;
    localparam int EMPH_SHIFT = 3;
    localparam int EMPH_W     = SAMPLE_W + $clog2(EMPH_NUM + 1);
    localparam int OUT_W      = 10;
    localparam int NUM_GRP    = 2;

    localparam int LOW_DIV  [NUM_SEL] = '{184, 166, 150, 136};
    localparam int HIGH_DIV [NUM_SEL] = '{106, 96, 86, 78};

    typedef logic [DIV_W-1:0]           div_t;
    typedef logic [PH_W-1:0]            phase_t;
    typedef logic [SEL_W-1:0]           sel_t;
    typedef logic signed [SAMPLE_W-1:0] sample_t;
    typedef logic signed [EMPH_W-1:0]   emph_t;
    typedef enum logic {GRP_LOW = 1'b0, GRP_HIGH = 1'b1} group_e;

    // Clocks per sine step for a group and selector value.
    function automatic div_t step_ratio(group_e grp, sel_t sel);
        if (grp == GRP_LOW) return div_t'(LOW_DIV[sel]);
        return div_t'(HIGH_DIV[sel]);
    endfunction

    // Rounded magnitude of PEAK*sin for steps 0..QUARTER of the cycle.
    function automatic sample_t quarter_mag(phase_t idx);
        case (idx)
            phase_t'(0): return sample_t'(0);
            phase_t'(1): return sample_t'(28);
            phase_t'(2): return sample_t'(55);
            phase_t'(3): return sample_t'(79);
            phase_t'(4): return sample_t'(99);
            phase_t'(5): return sample_t'(114);
            phase_t'(6): return sample_t'(124);
            phase_t'(7): return sample_t'(PEAK);
            default:     return sample_t'(0);
        endcase
    endfunction
endpackage

// File: rtl/tone_step_counter.sv
// tone_step_counter: counts reference clocks up to the step length and
// advances a wrapping step index at each terminal count.
// Assumes ratio >= 1 and ratio steady while en is high. Clearing en
// returns count and step to zero, so a tone always starts at step 0.
module tone_step_counter
    import tone_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   en,
    input  div_t   ratio,
    output phase_t phase,
    output div_t   count
);
    div_t   cnt_q;
    phase_t ph_q;
    logic   step_end;

    // Terminal count of the current step (>= keeps it bounded).
    assign step_end = (cnt_q >= (ratio - div_t'(1)));

    // Clock count and step index, cleared by reset or by a low enable.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt_q <= '0;
            ph_q  <= '0;
        end else if (step_end) begin
            cnt_q <= '0;
            ph_q  <= (ph_q == phase_t'(STEPS - 1)) ? '0 : ph_q + phase_t'(1);
        end else begin
            cnt_q <= cnt_q + div_t'(1);
        end
    end

    assign phase = ph_q;
    assign count = cnt_q;
endmodule

// File: rtl/tone_sine_rom.sv
// tone_sine_rom: maps a step index to a signed sine sample using
// quarter-wave symmetry. Outputs zero when the group is disabled.
// Assumes phase < STEPS.
module tone_sine_rom
    import tone_pkg::*;
(
    input  logic    en,
    input  phase_t  phase,
    output sample_t sample
);
    logic    neg_half;
    phase_t  in_half;
    phase_t  q_idx;
    sample_t mag;

    // Fold the step into the first quarter and pick the sign.
    always_comb begin
        neg_half = (phase >= phase_t'(HALF));
        in_half  = neg_half ? (phase - phase_t'(HALF)) : phase;
        q_idx    = (in_half > phase_t'(QUARTER)) ? (phase_t'(HALF) - in_half) : in_half;
        mag      = quarter_mag(q_idx);
        if (!en)
            sample = '0;
        else if (neg_half)
            sample = -mag;
        else
            sample = mag;
    end
endmodule

// File: rtl/tone_emphasis.sv
// tone_emphasis: scales a signed sample by EMPH_NUM / 2**EMPH_SHIFT
// with floor rounding (arithmetic shift). Pure combinational.
module tone_emphasis
    import tone_pkg::*;
(
    input  sample_t sample_in,
    output emph_t   sample_out
);
    localparam emph_t GAIN = emph_t'(EMPH_NUM);

    emph_t widened;
    emph_t product;

    // Widen, multiply and shift down by the gain denominator.
    always_comb begin
        widened    = emph_t'(sample_in);
        product    = widened * GAIN;
        sample_out = product >>> EMPH_SHIFT;
    end
endmodule

// File: rtl/tone_pair_synth.sv
// tone_pair_synth: two divided-clock sine generators (low and high group)
// whose samples are summed, with pre-emphasis on the high group, into a
// registered signed output word. Assumes clk is the tone reference clock
// and that each selector stays steady while its group is enabled.
module tone_pair_synth
    import tone_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    low_en,
    input  logic [SEL_W-1:0]        low_sel,
    input  logic                    high_en,
    input  logic [SEL_W-1:0]        high_sel,
    output logic signed [OUT_W-1:0] tone_out
);
    logic [NUM_GRP-1:0]            en_v;
    logic [NUM_GRP-1:0][SEL_W-1:0] sel_v;
    logic [NUM_GRP-1:0][DIV_W-1:0] ratio_v;
    logic [NUM_GRP-1:0][PH_W-1:0]  phase_v;
    logic [NUM_GRP-1:0][DIV_W-1:0] cnt_v;
    sample_t                       samp_v [NUM_GRP];
    emph_t                         high_emph;
    logic signed [OUT_W-1:0]       sum_d;
    logic signed [OUT_W-1:0]       out_q;

    assign en_v  = {high_en, low_en};
    assign sel_v = {high_sel, low_sel};

    // One step counter and sine lookup per tone group.
    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        phase_t ph_w;
        div_t   cnt_w;
        assign ratio_v[g] = step_ratio((g == 0) ? GRP_LOW : GRP_HIGH, sel_v[g]);

        tone_step_counter u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (en_v[g]),
            .ratio (ratio_v[g]),
            .phase (ph_w),
            .count (cnt_w)
        );

        tone_sine_rom u_rom (
            .en     (en_v[g]),
            .phase  (ph_w),
            .sample (samp_v[g])
        );

        assign phase_v[g] = ph_w;
        assign cnt_v[g]   = cnt_w;
    end

    tone_emphasis u_emph (
        .sample_in  (samp_v[1]),
        .sample_out (high_emph)
    );

    // Mix the low sample with the emphasised high sample.
    assign sum_d = OUT_W'(samp_v[0]) + OUT_W'(high_emph);

    // Output register, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            out_q <= '0;
        else
            out_q <= sum_d;
    end

    assign tone_out = out_q;
endmodule

// File: rtl/tone_pair_synth_chk.sv
// tone_pair_synth_chk: property checker bound into tone_pair_synth.
// Assumes selectors stay steady while their group is enabled.
module tone_pair_synth_chk
    import tone_pkg::*;
(
    input logic                          clk,
    input logic                          rst_n,
    input logic                          low_en,
    input logic                          high_en,
    input logic signed [OUT_W-1:0]       tone_out,
    input logic [NUM_GRP-1:0][PH_W-1:0]  phase_v,
    input logic [NUM_GRP-1:0][DIV_W-1:0] cnt_v,
    input logic [NUM_GRP-1:0][DIV_W-1:0] ratio_v
);
    logic [NUM_GRP-1:0] en_v;
    assign en_v = {high_en, low_en};

    // R7: both groups off gives a silent output word.
    p_idle_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!low_en && !high_en) |=> (tone_out == '0));

    // R8: output magnitude bound.
    p_out_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(tone_out) <= 301) && (int'(tone_out) >= -302));

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_chk
        // R5: a low enable clears step and count.
        p_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
            !en_v[g] |=> ((phase_v[g] == '0) && (cnt_v[g] == '0)));

        // R2 and R3: the count stays below the selected step length.
        p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
            cnt_v[g] < ratio_v[g]);

        // R4: the step index stays inside the 28-step cycle.
        p_phase_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
            phase_v[g] < phase_t'(STEPS));

        // R4: while enabled, the step only moves forward by one with wrap.
        p_phase_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(en_v[g]) && (phase_v[g] != $past(phase_v[g]))) |->
            (phase_v[g] == (($past(phase_v[g]) == phase_t'(STEPS - 1)) ?
                            phase_t'(0) : ($past(phase_v[g]) + phase_t'(1)))));
    end
endmodule

bind tone_pair_synth tone_pair_synth_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .low_en   (low_en),
    .high_en  (high_en),
    .tone_out (tone_out),
    .phase_v  (phase_v),
    .cnt_v    (cnt_v),
    .ratio_v  (ratio_v)
);

// File: tb/tone_pair_synth_tb_top.sv
// Bench for tone_pair_synth: behavioural model compared on every clock.
module tone_pair_synth_tb_top;
    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              low_en = 1'b0;
    logic [1:0]        low_sel = 2'd0;
    logic              high_en = 1'b0;
    logic [1:0]        high_sel = 2'd0;
    logic signed [9:0] tone_out;

    int    n_cmp = 0;
    int    n_bad = 0;
    int    cyc = 0;
    int    lo_k = 0;
    int    hi_k = 0;
    string cur_req = "R1";

    tone_pair_synth dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .low_en   (low_en),
        .low_sel  (low_sel),
        .high_en  (high_en),
        .high_sel (high_sel),
        .tone_out (tone_out)
    );

    always #10 clk = ~clk;

    function automatic int div_of(bit high, int sel);
        int lo_tab [4] = '{184, 166, 150, 136};
        int hi_tab [4] = '{106, 96, 86, 78};
        return high ? hi_tab[sel] : lo_tab[sel];
    endfunction

    function automatic int sine_ref(int p);
        real a;
        a = 2.0 * 3.14159265358979 * real'(p) / 28.0;
        return int'($sin(a) * 127.0);
    endfunction

    function automatic int emph_ref(int v);
        return $rtoi($floor(real'(v) * 11.0 / 8.0));
    endfunction

    // Model update and comparison on each falling edge.
    always @(negedge clk) begin
        int exp_v;
        int lo_s;
        int hi_s;
        if (!rst_n) begin
            lo_k  = 0;
            hi_k  = 0;
            exp_v = 0;
        end else begin
            lo_s = 0;
            hi_s = 0;
            if (low_en) begin
                lo_s = sine_ref((lo_k / div_of(1'b0, int'(low_sel))) % 28);
                lo_k++;
            end else lo_k = 0;
            if (high_en) begin
                hi_s = emph_ref(sine_ref((hi_k / div_of(1'b1, int'(high_sel))) % 28));
                hi_k++;
            end else hi_k = 0;
            exp_v = lo_s + hi_s;
        end
        n_cmp++;
        if (int'(tone_out) != exp_v) begin
            n_bad++;
            $display("FAIL %s t=%0t tone_out actual=%0d expected=%0d",
                     cur_req, $time, tone_out, exp_v);
        end
        // R8: independent magnitude check.
        n_cmp++;
        if (int'(tone_out) > 301 || int'(tone_out) < -302) begin
            n_bad++;
            $display("FAIL R8 t=%0t tone_out actual=%0d expected within -302..301",
                     $time, tone_out);
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc >= 200000) begin
            n_bad++;
            $display("FAIL watchdog actual=%0d cycles expected below 200000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic drive(input bit rn, input bit le, input int ls,
                         input bit he, input int hs);
        @(negedge clk);
        #1;
        rst_n    = rn;
        low_en   = le;
        low_sel  = 2'(ls);
        high_en  = he;
        high_sel = 2'(hs);
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        // R1: reset state.
        cur_req = "R1";
        wait_cyc(5);
        drive(1'b1, 1'b0, 0, 1'b0, 0);
        wait_cyc(3);
        // R2 R4 R5: low group alone, every selector, one full cycle each.
        cur_req = "R2/R4/R5";
        for (int s = 0; s < 4; s++) begin
            drive(1'b1, 1'b0, s, 1'b0, 0);
            drive(1'b1, 1'b1, s, 1'b0, 0);
            wait_cyc(div_of(1'b0, s) * 28 + 40);
        end
        drive(1'b1, 1'b0, 0, 1'b0, 0);
        cur_req = "R7";
        wait_cyc(4);
        // R3 R6: high group alone, every selector.
        cur_req = "R3/R6";
        for (int s = 0; s < 4; s++) begin
            drive(1'b1, 1'b0, 0, 1'b0, s);
            drive(1'b1, 1'b0, 0, 1'b1, s);
            wait_cyc(div_of(1'b1, s) * 28 + 40);
        end
        drive(1'b1, 1'b0, 0, 1'b0, 0);
        // R7: both groups together, several pairs.
        cur_req = "R7";
        for (int s = 0; s < 4; s++) begin
            drive(1'b1, 1'b0, s, 1'b0, 3 - s);
            drive(1'b1, 1'b1, s, 1'b1, 3 - s);
            wait_cyc(2500);
        end
        // R9: toggle the high group while the low group keeps running.
        cur_req = "R9";
        drive(1'b1, 1'b1, 3, 1'b0, 1);
        wait_cyc(700);
        drive(1'b1, 1'b1, 3, 1'b1, 1);
        wait_cyc(900);
        drive(1'b1, 1'b1, 3, 1'b0, 1);
        wait_cyc(500);
        // R5: one-cycle enable drop restarts the low group at step 0.
        cur_req = "R5";
        drive(1'b1, 1'b0, 1, 1'b1, 2);
        drive(1'b1, 1'b1, 1, 1'b1, 2);
        wait_cyc(1500);
        // R1: reset in mid-tone with enables held high.
        cur_req = "R1";
        drive(1'b0, 1'b1, 1, 1'b1, 2);
        wait_cyc(3);
        drive(1'b1, 1'b1, 1, 1'b1, 2);
        cur_req = "R5/R7";
        wait_cyc(2000);
        drive(1'b1, 1'b0, 0, 1'b0, 0);
        wait_cyc(5);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule